// File: doc/BRIEF.md
# Inter-Processor Shim Header Inserter

This block sits at the end of the first processing stage. A frame arrives as a byte stream. Its annotations (slice, code option, exception flags, result and stats indices, inner packet offset) arrive beside it as one sideband record. The block writes a fixed 16-byte shim over the front of the frame so that the annotations reach the second stage.

The shim takes the place of the outer 18-byte VLAN-tagged Ethernet header. The frame therefore gets no longer: the first two input bytes are discarded, input bytes 2 to 17 are replaced by shim bytes, and every later byte passes through unchanged. The block also reports the frame's new length and start offset, shifted by the two bytes that were removed.

One annotation record is accepted per frame, with a valid/ready handshake. The block takes no frame bytes until the record has been accepted. After the last byte of a frame it is ready for the next record.

Top module: `shim_inserter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `annReady` is 1, `inReady` is 0 and `outValid` is 0.
- R2: An annotation record is taken on a cycle where `annValid` and `annReady` are both high. After that, `annReady` stays low until the last byte of the frame (`inLast`) has been accepted.
- R3: While no annotation is held, `inReady` and `outValid` stay low, even when `inValid` is high.
- R4: The first two input bytes of a frame are accepted without producing any output byte.
- R5: The output frame starts with 16 shim bytes, most significant byte first. Bytes 0-1 are the slice ID, bytes 4-7 the result index, bytes 8-9 the stats index and bytes 10-11 the inner packet offset.
- R6: Shim byte 2 holds the 4-bit code option in bits 7:4 and exception bits 11:8 in bits 3:0. Shim byte 3 holds exception bits 7:0.
- R7: Shim bytes 12 to 15 are zero.
- R8: Input bytes from index 18 onward appear unchanged and in order after the shim. `outLast` marks the byte that came from the input's last byte.
- R9: Once a record is accepted, `outLen` equals its frame length minus 2 and `outStart` equals its start offset plus 2. Both hold until the next record is accepted.
- R10: When `outValid` is high and `outReady` is low, `inReady` is low, so no byte is lost or repeated.
- R11: After a frame's last byte is accepted, `annReady` returns high. The next frame's shim carries the new record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| annValid | input | 1 | Annotation record offered |
| annReady | output | 1 | Block can accept a record |
| annSliceId | input | 16 | Slice identifier |
| annCodeOpt | input | 4 | Code option |
| annExcBits | input | 12 | Exception flags |
| annResultIdx | input | 32 | Lookup result index |
| annStatsIdx | input | 16 | Statistics index |
| annInnerOff | input | 16 | Offset of the inner packet |
| annFrameLen | input | 16 | Input frame length in bytes |
| annFrameStart | input | 16 | Input frame start offset in the buffer |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted when valid |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Input byte is the frame's last |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts output byte |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Output byte is the frame's last |
| outLen | output | 16 | Rewritten frame length |
| outStart | output | 16 | Rewritten frame start offset |

## Verification
The assertions check the handshake rules on every cycle. They cover:
- the annotation lock-out and its release after the last byte,
- the absence of any input or output activity while no record is held,
- the stall rule under output backpressure,
- the derived length and its stability between records.

The bench scenarios are the only way to show the byte layout of the shim: field order, the shared code/exception byte and the zero pad. The same holds for the two dropped leading bytes, the unchanged payload and the last-byte marking, since these depend on the data values and on stall patterns.

// File: rtl/shim_pkg.sv
package shim_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [15:0] sliceId;
    logic [3:0]  codeOpt;
    logic [11:0] excBits;
    logic [31:0] resultIdx;
    logic [15:0] statsIdx;
    logic [15:0] innerOff;
    logic [15:0] frameLen;
    logic [15:0] frameStart;
  } annRec_t;

  localparam int FIELD_W = 16 + 4 + 12 + 32 + 16 + 16;

  typedef struct packed {
    logic capture;
    logic selShim;
  } dpCtl_t;
endpackage

// File: rtl/shim_ctrl.sv
module shim_ctrl
  import shim_pkg::*;
#(
  parameter int HDR_BYTES  = 18,
  parameter int SHIM_BYTES = 16,
  localparam int DROP_BYTES = HDR_BYTES - SHIM_BYTES,
  localparam int CNT_W = $clog2(HDR_BYTES + 1),
  localparam int IDX_W = $clog2(SHIM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             annValid,
  output logic             annReady,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output dpCtl_t           ctl,
  output logic [IDX_W-1:0] shimIdx
);
  logic [CNT_W-1:0] cnt;
  logic             haveAnn;
  logic             inDrop;
  logic             inShim;
  logic             inFire;
  logic [CNT_W-1:0] cntOff;

  assign inDrop   = cnt < CNT_W'(DROP_BYTES);
  assign inShim   = !inDrop && (cnt < CNT_W'(HDR_BYTES));
  assign annReady = !haveAnn;
  assign inReady  = haveAnn && (inDrop || outReady);
  assign outValid = haveAnn && inValid && !inDrop;
  assign inFire   = inValid && inReady;
  assign cntOff   = cnt - CNT_W'(DROP_BYTES);
  assign shimIdx  = cntOff[IDX_W-1:0];

  always_comb begin
    ctl.capture = annValid && !haveAnn;
    ctl.selShim = inShim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      haveAnn <= 1'b0;
    end else begin
      if (ctl.capture) haveAnn <= 1'b1;
      if (inFire) begin
        if (inLast) begin
          haveAnn <= 1'b0;
          cnt     <= '0;
        end else if (cnt < CNT_W'(HDR_BYTES)) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  ann_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (annValid && annReady) |=> !annReady);

  // R11
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> annReady);

  // R3
  no_ann_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    annReady |-> (!outValid && !inReady));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: rtl/shim_datapath.sv
module shim_datapath
  import shim_pkg::*;
#(
  parameter int HDR_BYTES  = 18,
  parameter int SHIM_BYTES = 16,
  localparam int SHIM_W  = SHIM_BYTES * BYTE_W,
  localparam int PAD_W   = SHIM_W - FIELD_W,
  localparam int IDX_W   = $clog2(SHIM_BYTES),
  localparam int DELTA   = HDR_BYTES - SHIM_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [IDX_W-1:0]  shimIdx,
  input  annRec_t           annIn,
  input  logic [BYTE_W-1:0] inData,
  output logic [BYTE_W-1:0] outData,
  output logic [15:0]       outLen,
  output logic [15:0]       outStart
);
  annRec_t           annReg;
  logic [SHIM_W-1:0] shimVec;
  logic [BYTE_W-1:0] shimBytes [SHIM_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) annReg <= '0;
    else if (ctl.capture) annReg <= annIn;
  end

  assign shimVec = {annReg.sliceId, annReg.codeOpt, annReg.excBits,
                    annReg.resultIdx, annReg.statsIdx, annReg.innerOff,
                    {PAD_W{1'b0}}};

  for (genvar g = 0; g < SHIM_BYTES; g++) begin : g_byte
    assign shimBytes[g] = shimVec[SHIM_W-1-BYTE_W*g -: BYTE_W];
  end

  assign outData  = ctl.selShim ? shimBytes[shimIdx] : inData;
  assign outLen   = annReg.frameLen - 16'(DELTA);
  assign outStart = annReg.frameStart + 16'(DELTA);

  // R9
  len_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (outLen == $past(annIn.frameLen) - 16'(DELTA)));

  // R9
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(outLen) && $stable(outStart)));
endmodule

// File: rtl/shim_inserter.sv
module shim_inserter
  import shim_pkg::*;
#(
  parameter int HDR_BYTES  = 18,
  parameter int SHIM_BYTES = 16,
  localparam int IDX_W = $clog2(SHIM_BYTES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        annValid,
  output logic        annReady,
  input  logic [15:0] annSliceId,
  input  logic [3:0]  annCodeOpt,
  input  logic [11:0] annExcBits,
  input  logic [31:0] annResultIdx,
  input  logic [15:0] annStatsIdx,
  input  logic [15:0] annInnerOff,
  input  logic [15:0] annFrameLen,
  input  logic [15:0] annFrameStart,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inData,
  input  logic        inLast,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outData,
  output logic        outLast,
  output logic [15:0] outLen,
  output logic [15:0] outStart
);
  annRec_t          annIn;
  dpCtl_t           ctl;
  logic [IDX_W-1:0] shimIdx;

  assign annIn = '{sliceId: annSliceId, codeOpt: annCodeOpt, excBits: annExcBits,
                   resultIdx: annResultIdx, statsIdx: annStatsIdx,
                   innerOff: annInnerOff, frameLen: annFrameLen,
                   frameStart: annFrameStart};
  assign outLast = inLast;

  shim_ctrl #(.HDR_BYTES(HDR_BYTES), .SHIM_BYTES(SHIM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .annValid(annValid), .annReady(annReady),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .ctl(ctl), .shimIdx(shimIdx));

  shim_datapath #(.HDR_BYTES(HDR_BYTES), .SHIM_BYTES(SHIM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shimIdx(shimIdx), .annIn(annIn),
    .inData(inData), .outData(outData), .outLen(outLen), .outStart(outStart));
endmodule

// File: tb/tb_shim_inserter.sv
module tb_shim_inserter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic annValid = 1'b0;
  logic annReady;
  logic [15:0] annSliceId = '0;
  logic [3:0]  annCodeOpt = '0;
  logic [11:0] annExcBits = '0;
  logic [31:0] annResultIdx = '0;
  logic [15:0] annStatsIdx = '0;
  logic [15:0] annInnerOff = '0;
  logic [15:0] annFrameLen = '0;
  logic [15:0] annFrameStart = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inData = '0;
  logic inLast = 1'b0;
  logic outValid;
  logic outReady = 1'b0;
  logic [7:0] outData;
  logic outLast;
  logic [15:0] outLen;
  logic [15:0] outStart;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shim_inserter dut (
    .clk(clk), .rstN(rstN), .annValid(annValid), .annReady(annReady),
    .annSliceId(annSliceId), .annCodeOpt(annCodeOpt), .annExcBits(annExcBits),
    .annResultIdx(annResultIdx), .annStatsIdx(annStatsIdx),
    .annInnerOff(annInnerOff), .annFrameLen(annFrameLen),
    .annFrameStart(annFrameStart), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast), .outLen(outLen), .outStart(outStart));

  // slice, code, exc, result, stats, inner, frameLen, frameStart, stall modulus
  localparam int NV = 4;
  localparam logic [135:0] VEC [NV] = '{
    {16'h0A5C, 4'h3, 12'hB71, 32'hDEADBEEF, 16'h1234, 16'h002A, 16'd20, 16'h0040, 8'd0},
    {16'hFFFF, 4'hF, 12'hFFF, 32'h01020304, 16'hABCD, 16'h0000, 16'd19, 16'h0000, 8'd2},
    {16'h0001, 4'h0, 12'h001, 32'h80000001, 16'h0F0F, 16'h0100, 16'd33, 16'h1FFE, 8'd3},
    {16'h7E81, 4'h9, 12'h5A5, 32'hCAFEF00D, 16'hFFFF, 16'hFFFF, 16'd40, 16'h0102, 8'd5}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dataOf(input int seed, input int i);
    return 8'(seed * 13 + i * 7 + 1);
  endfunction

  task automatic runFrame(input logic [135:0] v, input int seed);
    logic [7:0] expB [64];
    int flen, stall, inIdx, outIdx, guard;
    int shimErr, codeErr, padErr, passErr, lastErr, stallErr, dropErr;
    logic [127:0] sv;
    {annSliceId, annCodeOpt, annExcBits, annResultIdx, annStatsIdx, annInnerOff,
     annFrameLen, annFrameStart} = v[135:8];
    stall = int'(v[7:0]);
    flen = int'(annFrameLen);
    sv = {annSliceId, annCodeOpt, annExcBits, annResultIdx, annStatsIdx,
          annInnerOff, 32'h0};
    for (int k = 0; k < 16; k++) expB[k] = sv[127-8*k -: 8];
    for (int k = 18; k < flen; k++) expB[k-2] = dataOf(seed, k);

    @(negedge clk);
    annValid = 1'b1;
    #1;
    while (!annReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    annValid = 1'b0;
    #1;
    check(annReady == 1'b0, "R2", "annReady after capture", annReady, 0);
    check(outLen == 16'(flen - 2), "R9", "outLen", outLen, flen - 2);
    check(outStart == annFrameStart + 16'd2, "R9", "outStart", outStart,
          annFrameStart + 16'd2);

    inIdx = 0; outIdx = 0; guard = 0;
    shimErr = 0; codeErr = 0; padErr = 0; passErr = 0;
    lastErr = 0; stallErr = 0; dropErr = 0;
    while (outIdx < flen - 2 && guard < 2000) begin
      guard++;
      inValid  = (inIdx < flen);
      inData   = dataOf(seed, inIdx);
      inLast   = (inIdx == flen - 1);
      outReady = (stall == 0) || ((cyc % stall) != 0);
      #1;
      if (inIdx < 2 && inValid && outValid) dropErr++;
      if (outValid && !outReady && inReady) stallErr++;
      if (outValid && outReady) begin
        if (outData !== expB[outIdx]) begin
          if (outIdx == 2 || outIdx == 3) codeErr++;
          else if (outIdx >= 12 && outIdx < 16) padErr++;
          else if (outIdx < 16) shimErr++;
          else passErr++;
        end
        if (outLast !== (outIdx == flen - 3)) lastErr++;
        outIdx++;
      end
      if (inValid && inReady) inIdx++;
      @(posedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
    outReady = 1'b0;
    #1;
    check(outIdx == flen - 2, "R8", "output byte count", outIdx, flen - 2);
    check(inIdx == flen, "R8", "input bytes consumed", inIdx, flen);
    check(dropErr == 0, "R4", "output during first two bytes", dropErr, 0);
    check(shimErr == 0, "R5", "shim field byte mismatches", shimErr, 0);
    check(codeErr == 0, "R6", "code/exception byte mismatches", codeErr, 0);
    check(padErr == 0, "R7", "pad byte mismatches", padErr, 0);
    check(passErr == 0, "R8", "payload byte mismatches", passErr, 0);
    check(lastErr == 0, "R8", "last flag errors", lastErr, 0);
    check(stallErr == 0, "R10", "input taken while output stalled", stallErr, 0);
    check(annReady == 1'b1, "R11", "annReady after frame end", annReady, 1);
    check(outLen == 16'(flen - 2), "R9", "outLen held after frame", outLen, flen - 2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        done = 1'b1;
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(annReady == 1'b1, "R1", "annReady in reset", annReady, 1);
    check(inReady == 1'b0, "R1", "inReady in reset", inReady, 0);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check(annReady == 1'b1 && inReady == 1'b0 && outValid == 1'b0, "R1",
          "state after reset", {annReady, inReady, outValid}, 3'b100);

    // R3: frame bytes offered with no annotation are held back
    inValid = 1'b1; inData = 8'h55; outReady = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      check(inReady == 1'b0 && outValid == 1'b0, "R3", "no annotation stall",
            {inReady, outValid}, 0);
    end
    inValid = 1'b0; outReady = 1'b0;

    for (int n = 0; n < NV; n++) runFrame(VEC[n], n + 1);
    // R11: back-to-back reuse of the first record after a different one
    runFrame(VEC[0], 9);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule